// File: doc/BRIEF.md
# Configurable SPI Master Peripheral

A byte-wide serial host port of the kind found beside a small processor core. Software programs a control register, then writes a byte into the data register. The block drives the shift clock, sends that byte out on its serial output and, during the same eight bit times, collects a byte from its serial input. When the eighth bit is in, a completion flag goes up and the received byte is waiting in the data register.

The clock idle level and the sampling edge are programmable, giving all four clock modes. Either end of the byte can go first. The shift clock period is one of four system-clock divisors, and a double-speed bit halves it. An active-low select input watches for another host on the bus. If it is pulled low while the block is an enabled host, the block gives up the host role and abandons any transfer in progress.

Top module: `spi_host_port`

## Requirements
- R1: After reset, all three registers read 0x00, the shift clock is low and the serial output is low.
- R2: Control register (address 0) fields are: bit0 enable, bit1 host role, bit2 clock idle level, bit3 sample-on-trailing-edge, bit4 low-bit-first, bits6:5 rate, bit7 reads 0. Status register (address 1) fields are: bit0 double speed (read/write), bit6 role-lost flag (read-only), bit7 transfer-done flag (read-only). The data register is at address 2. Every writable field reads back what was written.
- R3: While no transfer runs, the shift clock sits at the programmed idle level. During a transfer it returns to that level after every second edge.
- R4: The shift clock half period, in system clocks, is 2, 8, 32 or 64 for rate 0 to 3, and 1, 4, 16 or 32 with double speed. The first edge comes one half period after the clock edge that captures the data write.
- R5: A transfer makes exactly 16 shift clock edges.
- R6: With bit3=0, the first outgoing bit is on the serial output from the capture of the data write onward. The input is sampled on the leading (odd-numbered) edges and the output changes on the trailing edges.
- R7: With bit3=1, the output changes on the leading edges, starting with the first one, and the input is sampled on the trailing edges.
- R8: With bit4=0, bit 7 goes out first and the first bit received lands in bit 7. With bit4=1, bit 0 goes first on both sides.
- R9: The done flag and the received byte in the data register appear on the same clock edge as the 16th shift clock edge.
- R10: The done flag clears only when the data register is accessed after a status read that saw the flag set. A data access without that status read leaves the flag set.
- R11: A data write starts a transfer only when enable and host role are both 1 and no transfer is running. A data write during a transfer changes neither the byte being sent nor the byte received.
- R12: The select input low while enable and host role are 1 clears the host role bit and sets the role-lost flag. On the next clock it also stops the transfer, returns the shift clock to its idle level, and leaves the done flag clear.
- R13: Writing the control register with the host role bit set clears the role-lost flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (enables read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sclk_o | output | 1 | Shift clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low select input; low demotes the host |

## Verification
Every timed result is counted from the clock edge that captures the data write. Edge n of the shift clock is due n half periods later, and the done flag and the received byte are due on the edge of the 16th. A demotion takes effect on the first edge after the select input falls. The bench drives the bus and the select input at falling clock edges and counts falling edges from the write. It checks each gap between shift clock changes against the half period for the active rate, so a check lands exactly where the first register in the path updates. It reads the mode sampled bits at the first falling edge after each sampling edge, and it reads the status and data registers only once the 16th edge has been seen.

// File: rtl/spi_host_pkg.sv
// Shared constants for the serial host port: register addresses and
// field positions. Assumes an 8-bit register bus with a 2-bit address.
package spi_host_pkg;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2
    } reg_addr_e;

    // control register field positions
    localparam int CB_EN   = 0;
    localparam int CB_MST  = 1;
    localparam int CB_POL  = 2;
    localparam int CB_PHA  = 3;
    localparam int CB_LSB  = 4;
    localparam int CB_RATE = 5;

    // status register field positions
    localparam int SB_DBL  = 0;
    localparam int SB_LOST = 6;
    localparam int SB_DONE = 7;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_host_regs.sv
// Register file of the serial host port: control, status and data
// registers, done/role-lost flags and the select-input demotion.
// Assumes single-cycle bus strobes and a combinational read path.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ss_n_i,
    input  logic          xfer_busy_i,
    input  logic          xfer_done_i,
    input  logic [DW-1:0] rx_byte_i,
    output logic          start_o,
    output logic          abort_o,
    output logic [DW-1:0] tx_byte_o,
    output logic          cpol_o,
    output logic          cpha_o,
    output logic          lsb_o,
    output logic [1:0]    rate_o,
    output logic          dbl_o
);

    logic          en_q, mst_q, pol_q, pha_q, lsb_q, dbl_q;
    logic [1:0]    rate_q;
    logic          done_q, lost_q, armed_q;
    logic [DW-1:0] data_q;
    logic          wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
    logic          demote, flag_clear;

    // decode the bus strobe into per-register accesses
    always_comb begin
        wr_ctrl = bus_sel && bus_wr && (bus_addr == RA_CTRL);
        wr_stat = bus_sel && bus_wr && (bus_addr == RA_STAT);
        wr_data = bus_sel && bus_wr && (bus_addr == RA_DATA);
        rd_stat = bus_sel && bus_rd && (bus_addr == RA_STAT);
        rd_data = bus_sel && bus_rd && (bus_addr == RA_DATA);
    end

    // demotion, start and flag-clear conditions
    always_comb begin
        demote     = en_q && mst_q && !ss_n_i;
        start_o    = wr_data && en_q && mst_q && !xfer_busy_i && !demote;
        flag_clear = (wr_data || rd_data) && armed_q && done_q;
    end

    assign abort_o   = demote;
    assign tx_byte_o = bus_wdata;
    assign cpol_o    = pol_q;
    assign cpha_o    = pha_q;
    assign lsb_o     = lsb_q;
    assign rate_o    = rate_q;
    assign dbl_o     = dbl_q;

    // control register fields other than the host role bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            pha_q  <= 1'b0;
            lsb_q  <= 1'b0;
            rate_q <= 2'd0;
        end else if (wr_ctrl) begin
            en_q   <= bus_wdata[CB_EN];
            pol_q  <= bus_wdata[CB_POL];
            pha_q  <= bus_wdata[CB_PHA];
            lsb_q  <= bus_wdata[CB_LSB];
            rate_q <= bus_wdata[CB_RATE +: 2];
        end
    end

    // host role bit and role-lost flag; demotion wins over a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q  <= 1'b0;
            lost_q <= 1'b0;
        end else if (demote) begin
            mst_q  <= 1'b0;
            lost_q <= 1'b1;
        end else if (wr_ctrl) begin
            mst_q  <= bus_wdata[CB_MST];
            if (bus_wdata[CB_MST]) lost_q <= 1'b0;
        end
    end

    // double-speed bit, the only writable status field
    always_ff @(posedge clk) begin
        if (!rst_n)       dbl_q <= 1'b0;
        else if (wr_stat) dbl_q <= bus_wdata[SB_DBL];
    end

    // data register: received byte on completion, idle writes otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                         data_q <= '0;
        else if (xfer_done_i)               data_q <= rx_byte_i;
        else if (wr_data && !xfer_busy_i)   data_q <= bus_wdata;
    end

    // done flag with its two-step clear sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (xfer_done_i)     done_q <= 1'b1;
            else if (flag_clear) done_q <= 1'b0;
            if (flag_clear || start_o)  armed_q <= 1'b0;
            else if (rd_stat && done_q) armed_q <= 1'b1;
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL: begin
                bus_rdata[CB_EN]        = en_q;
                bus_rdata[CB_MST]       = mst_q;
                bus_rdata[CB_POL]       = pol_q;
                bus_rdata[CB_PHA]       = pha_q;
                bus_rdata[CB_LSB]       = lsb_q;
                bus_rdata[CB_RATE +: 2] = rate_q;
            end
            RA_STAT: begin
                bus_rdata[SB_DBL]  = dbl_q;
                bus_rdata[SB_LOST] = lost_q;
                bus_rdata[SB_DONE] = done_q;
            end
            RA_DATA: bus_rdata = data_q;
            default: bus_rdata = '0;
        endcase
    end

    // R12: a low select input on an enabled host removes the host role
    a_r12_demote_clears_role: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mst_q && !ss_n_i) |=> (!mst_q && lost_q));

    // R9: the done flag only rises after a completion from the shifter
    a_r9_flag_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(xfer_done_i));

    // R10: without a data access the done flag holds
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(bus_sel && (bus_wr || bus_rd) && bus_addr == RA_DATA)) |=> done_q);

endmodule

// File: rtl/spi_host_baud.sv
// Half-period timer for the shift clock. Emits one tick per half period
// while a transfer runs. Assumes every divisor is a multiple of 4 and
// that rate and double speed are stable during a transfer.
module spi_host_baud
    import spi_host_pkg::*;
#(
    parameter int DIV_R0 = 4,
    parameter int DIV_R1 = 16,
    parameter int DIV_R2 = 64,
    parameter int DIV_R3 = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    input  logic       dbl_i,
    output logic       tick_o
);

    localparam int HALF_MAX = max_int(max_int(DIV_R0, DIV_R1), max_int(DIV_R2, DIV_R3)) / 2;
    localparam int CW       = $clog2(HALF_MAX + 1);

    logic [CW-1:0] cnt_q, lim, lim_m1;

    // half period in system clocks for the selected rate
    always_comb begin
        case (rate_i)
            2'd0:    lim = dbl_i ? CW'(DIV_R0 / 4) : CW'(DIV_R0 / 2);
            2'd1:    lim = dbl_i ? CW'(DIV_R1 / 4) : CW'(DIV_R1 / 2);
            2'd2:    lim = dbl_i ? CW'(DIV_R2 / 4) : CW'(DIV_R2 / 2);
            default: lim = dbl_i ? CW'(DIV_R3 / 4) : CW'(DIV_R3 / 2);
        endcase
        lim_m1 = lim - CW'(1);
    end

    assign tick_o = run_i && (cnt_q >= lim_m1);

    // count system clocks within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)     cnt_q <= '0;
        else if (cnt_q >= lim_m1) cnt_q <= '0;
        else                      cnt_q <= cnt_q + CW'(1);
    end

    // R4: ticks are never adjacent unless the half period is one clock
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim > CW'(1) && $stable(rate_i) && $stable(dbl_i)) |=> !tick_o);

endmodule

// File: rtl/spi_host_shift.sv
// Shift engine: makes the 16 shift clock edges of one byte exchange,
// drives the serial output and samples the serial input on the edges
// the clock mode selects, in the chosen bit order. Assumes the mode
// bits are stable while busy.
module spi_host_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          tick_i,
    input  logic [DW-1:0] tx_byte_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic          lsb_i,
    input  logic          miso_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          sclk_o,
    output logic          mosi_o
);

    localparam int EDGES = 2 * DW;
    localparam int ECW   = $clog2(EDGES + 1);

    logic          busy_q, sclk_q, mosi_q;
    logic [ECW-1:0] edge_q, edge_n;
    logic [DW-1:0] tx_q, rx_q, tx_shift, rx_next;
    logic          leading, sample_ev, drive_ev, last_ev, out_bit, first_bit;

    // edge classification for the tick about to happen
    always_comb begin
        edge_n    = edge_q + ECW'(1);
        leading   = edge_n[0];
        sample_ev = busy_q && tick_i && (cpha_i ? !leading : leading);
        drive_ev  = busy_q && tick_i &&
                    (cpha_i ? leading : (!leading && edge_n != ECW'(EDGES)));
        last_ev   = busy_q && tick_i && (edge_n == ECW'(EDGES));
    end

    // bit order: pick the outgoing bit and the shifted registers
    always_comb begin
        out_bit   = lsb_i ? tx_q[0] : tx_q[DW-1];
        tx_shift  = lsb_i ? (tx_q >> 1) : (tx_q << 1);
        rx_next   = lsb_i ? {miso_i, rx_q[DW-1:1]} : {rx_q[DW-2:0], miso_i};
        first_bit = lsb_i ? tx_byte_i[0] : tx_byte_i[DW-1];
    end

    // transfer sequencing, clock toggling and data shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            edge_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
            edge_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            edge_q <= '0;
            sclk_q <= cpol_i;
            rx_q   <= '0;
            if (!cpha_i) begin
                mosi_q <= first_bit;
                tx_q   <= lsb_i ? (tx_byte_i >> 1) : (tx_byte_i << 1);
            end else begin
                tx_q   <= tx_byte_i;
            end
        end else if (busy_q && tick_i) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_n;
            if (sample_ev) rx_q <= rx_next;
            if (drive_ev) begin
                mosi_q <= out_bit;
                tx_q   <= tx_shift;
            end
            if (last_ev) busy_q <= 1'b0;
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = last_ev;
    assign rx_byte_o = sample_ev ? rx_next : rx_q;
    assign sclk_o    = busy_q ? sclk_q : cpol_i;
    assign mosi_o    = mosi_q;

    // R3: after every even number of edges the clock is back at idle
    a_r3_even_edges_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !edge_q[0] && $stable(cpol_i)) |-> (sclk_q == cpol_i));

    // R3: the clock only moves on a half-period tick
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick_i && !abort_i) |=> $stable(sclk_q));

    // R5: the edge count never reaches 16 while still busy
    a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (edge_q < ECW'(EDGES)));

    // R12: an abort stops the transfer on the next clock
    a_r12_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_q);

endmodule

// File: rtl/spi_host_port.sv
// Top of the serial host port: register file, half-period timer and
// shift engine. Assumes ss_n_i is already synchronous to clk.
module spi_host_port #(
    parameter int DW     = 8,
    parameter int DIV_R0 = 4,
    parameter int DIV_R1 = 16,
    parameter int DIV_R2 = 64,
    parameter int DIV_R3 = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sclk_o,
    output logic          mosi_o,
    input  logic          miso_i,
    input  logic          ss_n_i
);

    logic          start, abort, busy, done, tick;
    logic          cpol, cpha, lsb, dbl;
    logic [1:0]    rate;
    logic [DW-1:0] tx_byte, rx_byte;

    spi_host_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ss_n_i      (ss_n_i),
        .xfer_busy_i (busy),
        .xfer_done_i (done),
        .rx_byte_i   (rx_byte),
        .start_o     (start),
        .abort_o     (abort),
        .tx_byte_o   (tx_byte),
        .cpol_o      (cpol),
        .cpha_o      (cpha),
        .lsb_o       (lsb),
        .rate_o      (rate),
        .dbl_o       (dbl)
    );

    spi_host_baud #(
        .DIV_R0 (DIV_R0),
        .DIV_R1 (DIV_R1),
        .DIV_R2 (DIV_R2),
        .DIV_R3 (DIV_R3)
    ) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .rate_i (rate),
        .dbl_i  (dbl),
        .tick_o (tick)
    );

    spi_host_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .abort_i   (abort),
        .tick_i    (tick),
        .tx_byte_i (tx_byte),
        .cpol_i    (cpol),
        .cpha_i    (cpha),
        .lsb_i     (lsb),
        .miso_i    (miso_i),
        .busy_o    (busy),
        .done_o    (done),
        .rx_byte_o (rx_byte),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o)
    );

endmodule

// File: tb/spi_host_port_bench.sv
module spi_host_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic       ss_n = 1'b1;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    spi_host_port u_spi_host_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk_o    (sclk),
        .mosi_o    (mosi),
        .miso_i    (miso),
        .ss_n_i    (ss_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic int half_of(input int rate, input bit dbl);
        int div;
        div = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
        return dbl ? div / 4 : div / 2;
    endfunction

    function automatic logic wbit(input logic [7:0] b, input int i, input bit lsb);
        return lsb ? b[i] : b[7 - i];
    endfunction

    // one full exchange in a given mode, checked edge by edge
    task automatic run_xfer(input bit pol, input bit pha, input bit lsb, input int rate,
                            input bit dbl, input logic [7:0] tx, input logic [7:0] slv,
                            input bit collide);
        logic [7:0] rd;
        logic       prev;
        int         h, edges, last_k, k, gap_bad, bit_bad, m;
        h = half_of(rate, dbl);
        bus_write(2'd0, {1'b0, rate[1:0], lsb, pha, pol, 2'b11});
        bus_write(2'd1, {7'd0, dbl});
        chk(sclk == pol, "R3 idle level before start", sclk, pol);
        miso = pha ? 1'b0 : wbit(slv, 0, lsb);
        bus_write(2'd2, tx);
        if (!pha) chk(mosi == wbit(tx, 0, lsb), "R6 first bit before first edge", mosi, wbit(tx, 0, lsb));
        prev = sclk; edges = 0; last_k = 0; k = 0; gap_bad = 0; bit_bad = 0;
        while (edges < 16 && k < 4000) begin
            @(negedge clk);
            k++;
            if (collide && k == 2) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~tx;
            end
            if (collide && k == 3) begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            if (sclk != prev) begin
                edges++;
                if (k - last_k != h) gap_bad++;
                last_k = k;
                prev = sclk;
                if (pha ? (edges % 2 == 0) : (edges % 2 == 1)) begin
                    m = pha ? edges / 2 - 1 : (edges - 1) / 2;
                    if (mosi != wbit(tx, m, lsb)) bit_bad++;
                end
                if (pha && edges % 2 == 1) miso = wbit(slv, (edges - 1) / 2, lsb);
                if (!pha && edges % 2 == 0 && edges < 16) miso = wbit(slv, edges / 2, lsb);
            end
        end
        chk(edges == 16, "R5 edge count", edges, 16);
        chk(gap_bad == 0, "R4 half period spacing", gap_bad, 0);
        chk(bit_bad == 0, pha ? "R7 output bits at trailing samples" : "R6 output bits at leading samples",
            bit_bad, 0);
        bus_read(2'd1, rd);
        chk(rd[7] == 1'b1, "R9 done flag after 16th edge", rd, 8'h80 | dbl);
        chk(sclk == pol, "R3 idle level after transfer", sclk, pol);
        bus_read(2'd2, rd);
        chk(rd == slv, collide ? "R11 received byte with write during transfer" : "R8 received byte order",
            rd, slv);
        bus_read(2'd1, rd);
        chk(rd[7] == 1'b0, "R10 flag cleared by status then data", rd, dbl);
    endtask

    // watchdog: a hung run is a failure and still reports
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rd;
        int         idx, moves;
        logic       prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, rd); chk(rd == 8'h00, "R1 control after reset", rd, 0);
        bus_read(2'd1, rd); chk(rd == 8'h00, "R1 status after reset", rd, 0);
        bus_read(2'd2, rd); chk(rd == 8'h00, "R1 data after reset", rd, 0);
        chk(sclk == 1'b0 && mosi == 1'b0, "R1 pins after reset", {sclk, mosi}, 0);

        // R2 field readback, role and enable off
        bus_write(2'd0, 8'hFC);
        bus_read(2'd0, rd); chk(rd == 8'h7C, "R2 control readback", rd, 8'h7C);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, rd); chk(rd == 8'h01, "R2 status writable bits", rd, 8'h01);
        chk(sclk == 1'b1, "R3 idle high with bit2 set", sclk, 1);
        bus_write(2'd1, 8'h00);

        // R11 no start without enable, then without host role
        for (int v = 0; v < 2; v++) begin
            bus_write(2'd0, v == 0 ? 8'h02 : 8'h01);
            prev = sclk; moves = 0;
            bus_write(2'd2, 8'h33);
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (sclk != prev) moves++;
                prev = sclk;
            end
            chk(moves == 0, "R11 no clock without enable and role", moves, 0);
            bus_read(2'd1, rd); chk(rd[7] == 1'b0, "R11 no done without start", rd, 0);
            bus_read(2'd2, rd); chk(rd == 8'h33, "R11 idle write stored", rd, 8'h33);
        end

        // near-exhaustive sweep of modes, orders and rates
        idx = 0;
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int r = 0; r < 4; r++) begin
                for (int d = 0; d < 2; d++) begin
                    run_xfer(cfg[0], cfg[1], cfg[2], r, d[0], 8'(8'hA5 ^ (idx * 37)),
                             8'(8'h3C + idx * 53), (idx % 5) == 0);
                    idx++;
                end
            end
        end

        // R10 a data access without a prior status read keeps the flag
        miso = 1'b1;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h03);
        bus_write(2'd2, 8'h12);
        repeat (40) @(negedge clk);
        bus_read(2'd2, rd); chk(rd == 8'hFF, "R9 byte from constant input", rd, 8'hFF);
        bus_read(2'd1, rd); chk(rd[7] == 1'b1, "R10 flag kept after plain data read", rd, 8'h80);
        bus_read(2'd2, rd);
        bus_read(2'd1, rd); chk(rd[7] == 1'b0, "R10 flag cleared after sequence", rd, 0);

        // R12 demotion mid transfer, idle level high
        miso = 1'b0;
        bus_write(2'd0, 8'h67);
        bus_write(2'd2, 8'h5A);
        repeat (100) @(negedge clk);
        chk(sclk == 1'b0, "R12 clock active before demotion", sclk, 0);
        ss_n = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b1, "R12 clock back to idle", sclk, 1);
        bus_read(2'd0, rd); chk(rd == 8'h65, "R12 host role cleared", rd, 8'h65);
        bus_read(2'd1, rd); chk(rd == 8'h40, "R12 role-lost flag set", rd, 8'h40);
        bus_write(2'd2, 8'hC3);
        prev = sclk; moves = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (sclk != prev) moves++;
            prev = sclk;
        end
        chk(moves == 0, "R12 no clock after demotion", moves, 0);
        bus_read(2'd1, rd); chk(rd == 8'h40, "R12 no done after abort", rd, 8'h40);

        // R13 restoring the role clears the lost flag
        ss_n = 1'b1;
        bus_write(2'd0, 8'h67);
        bus_read(2'd1, rd); chk(rd == 8'h00, "R13 lost flag cleared", rd, 0);
        run_xfer(1'b1, 1'b0, 1'b0, 0, 1'b0, 8'h96, 8'h69, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule